// File: doc/BRIEF.md
# Parallel Host Port Receive Buffer Writer

This block takes bytes from a host over a classic parallel printer port and stores them in a circular receive area of a shared memory. The host places a byte on an 8-bit bus and pulses an active-low strobe. The block captures the byte and raises BUSY. It then issues one write request on a simple memory-side port and waits for that write to complete. After that it pulses an active-low ACK for a fixed number of cycles and releases BUSY. The host and initialize lines are asynchronous to the block clock. They pass through a synchronizer, and the byte is taken on the strobe's rising edge as seen after synchronization.

On the consumer side, firmware reads the fill level and moves the read pointer forward by writing a new value. The buffer has two capacities. A large one is used in normal operation and a small one is used while a font-download mode holds most of the memory. Any change of mode clears both pointers, so the fill level is never computed against the wrong limit. A host initialize request drives BUSY high at once, with no clock involved, and raises a request to the CPU. BUSY stays high until the CPU acknowledges, and that acknowledge also empties the buffer.

Top module: `prb_port_rx`

## Requirements
- R1: One strobe rising edge seen in the idle state stores the byte that was on the data bus. A single write request then carries that byte at address BUF_BASE plus the write pointer. The request, address and data hold steady until the write acknowledge input is sampled high.
- R2: BUSY is high from strobe detection until the end of the ACK pulse. ACK goes low on the cycle after the write acknowledge and stays low for exactly ACK_CYCLES cycles. BUSY then drops unless another hold condition applies.
- R3: The write pointer advances by one per completed write and returns to 0 after the last location of the active capacity.
- R4: The fill level equals (write pointer minus read pointer) modulo the active capacity. When it reaches capacity minus one, BUSY stays high, and a strobe in that state starts no write and leaves the fill level unchanged.
- R5: A low level on the initialize input drives BUSY high in the same cycle, before any clock edge.
- R6: The initialize request output rises after synchronization and stays high until the acknowledge input is sampled high with the initialize input released. That acknowledge sets both pointers to 0.
- R7: Strobes that arrive while initialize is low, or while the request is still waiting for acknowledge, start no write.
- R8: The mode input selects the capacity: 0 selects CAP_NORM and 1 selects CAP_FONT. Any change of mode sets both pointers to 0 on the next cycle.
- R9: A read-pointer update is taken only when the new value is below the active capacity. Otherwise it is ignored.
- R10: After reset, BUSY is low, ACK is high, no write is requested, the fill level is 0 and no initialize request is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| hdata_i | input | 8 | Host data bus |
| hstrobe_ni | input | 1 | Host data strobe, active low |
| hinit_ni | input | 1 | Host initialize, active low |
| hbusy_o | output | 1 | BUSY to host |
| hack_no | output | 1 | ACK to host, active low |
| bw_req_o | output | 1 | Buffer write request |
| bw_addr_o | output | ADDR_W | Buffer write byte address |
| bw_data_o | output | 8 | Buffer write data |
| bw_ack_i | input | 1 | Buffer write completed |
| font_mode_i | input | 1 | 1 selects the reduced capacity |
| rd_we_i | input | 1 | Read-pointer update strobe |
| rd_ptr_i | input | PTR_W | New read pointer |
| fill_o | output | PTR_W | Bytes held in the buffer |
| init_req_o | output | 1 | Initialize request to CPU |
| init_ack_i | input | 1 | CPU acknowledge of initialize |

## Verification
Bytes are sent with a write latency of zero and with a latency of several cycles. Comparing the two shows whether the request is held and whether the ACK timing depends on the write acknowledge rather than on the strobe. A long run in the small-capacity mode, with periodic pointer updates, drives the write pointer through its wrap point. Separate runs fill the buffer to one below capacity and assert initialize while bytes are stored. Each of those runs is followed by strobes that must be ignored. Pointer updates of values inside and outside the capacity, together with mode switches while the buffer holds data, show the limit selection and the clearing on a mode change.

// File: rtl/prb_pkg.sv
package prb_pkg;

   typedef enum logic [1:0] {
      PRB_IDLE  = 2'd0,
      PRB_STORE = 2'd1,
      PRB_ACK   = 2'd2
   } prb_state_e;

   function automatic int prb_max(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/prb_sync.sv
module prb_sync #(
   parameter int             W       = 1,
   parameter int             STAGES  = 2,
   parameter logic [W-1:0]   RST_VAL = '0
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);

   if (STAGES < 1) begin : g_bad_stages
      $error("prb_sync: STAGES must be at least 1");
   end

   if (STAGES == 1) begin : g_single
      logic [W-1:0] stg_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) stg_q <= RST_VAL;
         else         stg_q <= d_i;
      end
      assign q_o = stg_q;
   end else begin : g_chain
      logic [STAGES-1:0][W-1:0] stg_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) stg_q <= {STAGES{RST_VAL}};
         else         stg_q <= {stg_q[STAGES-2:0], d_i};
      end
      assign q_o = stg_q[STAGES-1];
   end

endmodule

// File: rtl/prb_ring.sv
module prb_ring #(
   parameter int PTR_W    = 16,
   parameter int CAP_NORM = 37888,
   parameter int CAP_FONT = 3072
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             font_mode_i,
   input  logic             clr_i,
   input  logic             adv_i,
   input  logic             rd_we_i,
   input  logic [PTR_W-1:0] rd_ptr_i,
   output logic [PTR_W-1:0] wptr_o,
   output logic [PTR_W-1:0] fill_o,
   output logic             full_o
);

   localparam logic [PTR_W:0] CAP_N = (PTR_W+1)'(CAP_NORM);
   localparam logic [PTR_W:0] CAP_F = (PTR_W+1)'(CAP_FONT);

   if (CAP_NORM < 2 || CAP_FONT < 2) begin : g_bad_cap
      $error("prb_ring: capacities must be at least 2");
   end
   if (CAP_NORM > (1 << PTR_W) || CAP_FONT > (1 << PTR_W)) begin : g_bad_ptr
      $error("prb_ring: PTR_W too narrow for capacity");
   end

   logic             mode_q;
   logic             mode_chg;
   logic [PTR_W:0]   cap;
   logic [PTR_W-1:0] w_q, r_q;
   logic [PTR_W:0]   w_inc;
   logic [PTR_W-1:0] w_nxt;
   logic [PTR_W:0]   span;
   logic             rd_ok;

   assign cap      = mode_q ? CAP_F : CAP_N;
   assign mode_chg = font_mode_i ^ mode_q;
   assign w_inc    = {1'b0, w_q} + 1'b1;
   assign w_nxt    = (w_inc == cap) ? '0 : w_inc[PTR_W-1:0];
   assign rd_ok    = ({1'b0, rd_ptr_i} < cap);

   always_comb begin
      if (w_q >= r_q) span = {1'b0, w_q} - {1'b0, r_q};
      else            span = cap - {1'b0, r_q} + {1'b0, w_q};
   end

   assign fill_o = span[PTR_W-1:0];
   assign full_o = (span == cap - 1'b1);
   assign wptr_o = w_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         mode_q <= 1'b0;
         w_q    <= '0;
         r_q    <= '0;
      end else begin
         mode_q <= font_mode_i;
         if (clr_i || mode_chg) begin
            w_q <= '0;
            r_q <= '0;
         end else begin
            if (adv_i)            w_q <= w_nxt;
            if (rd_we_i && rd_ok) r_q <= rd_ptr_i;
         end
      end
   end

   // R3
   wptr_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ({1'b0, w_q} < cap));

   // R3
   wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (adv_i && !clr_i && !mode_chg && (w_inc == cap)) |=> (w_q == '0));

   // R8
   mode_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      mode_chg |=> (fill_o == '0));

   // R6
   ptr_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      clr_i |=> (fill_o == '0));

endmodule

// File: rtl/prb_hshake.sv
module prb_hshake
   import prb_pkg::*;
#(
   parameter int ACK_CYCLES = 8
) (
   input  logic       clk_i,
   input  logic       rst_ni,
   input  logic       rise_i,
   input  logic [7:0] data_i,
   input  logic       init_act_i,
   input  logic       hold_i,
   input  logic       wr_ack_i,
   output logic       busy_o,
   output logic       ack_n_o,
   output logic       req_o,
   output logic [7:0] byte_o,
   output logic       adv_o
);

   localparam int CW = $clog2(ACK_CYCLES + 1);

   if (ACK_CYCLES < 1) begin : g_bad_ack
      $error("prb_hshake: ACK_CYCLES must be at least 1");
   end

   prb_state_e    state_q;
   logic [CW-1:0] cnt_q;
   logic [7:0]    byte_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         state_q <= PRB_IDLE;
         cnt_q   <= '0;
         byte_q  <= '0;
      end else if (init_act_i) begin
         state_q <= PRB_IDLE;
         cnt_q   <= '0;
      end else begin
         unique case (state_q)
            PRB_IDLE: begin
               if (rise_i && !hold_i) begin
                  byte_q  <= data_i;
                  state_q <= PRB_STORE;
               end
            end
            PRB_STORE: begin
               if (wr_ack_i) begin
                  state_q <= PRB_ACK;
                  cnt_q   <= CW'(ACK_CYCLES - 1);
               end
            end
            PRB_ACK: begin
               if (cnt_q == '0) state_q <= PRB_IDLE;
               else             cnt_q   <= cnt_q - 1'b1;
            end
            default: state_q <= PRB_IDLE;
         endcase
      end
   end

   assign busy_o  = (state_q != PRB_IDLE);
   assign ack_n_o = (state_q != PRB_ACK);
   assign req_o   = (state_q == PRB_STORE);
   assign byte_o  = byte_q;
   assign adv_o   = (state_q == PRB_STORE) && wr_ack_i && !init_act_i;

   logic [CW:0] ack_run_q;
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       ack_run_q <= '0;
      else if (!ack_n_o) ack_run_q <= ack_run_q + 1'b1;
      else               ack_run_q <= '0;
   end

   // R2
   ack_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($rose(ack_n_o) && !$past(init_act_i)) |-> (ack_run_q == (CW+1)'(ACK_CYCLES)));

   // R1
   req_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (req_o && !wr_ack_i && !init_act_i) |=> (req_o && $stable(byte_o)));

endmodule

// File: rtl/prb_port_rx.sv
module prb_port_rx #(
   parameter int  ADDR_W      = 16,
   parameter int  BUF_BASE    = 0,
   parameter int  CAP_NORM    = 37888,
   parameter int  CAP_FONT    = 3072,
   parameter int  ACK_CYCLES  = 8,
   parameter int  SYNC_STAGES = 2,
   localparam int PTR_W       = $clog2(prb_pkg::prb_max(CAP_NORM, CAP_FONT))
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic [7:0]        hdata_i,
   input  logic              hstrobe_ni,
   input  logic              hinit_ni,
   output logic              hbusy_o,
   output logic              hack_no,
   output logic              bw_req_o,
   output logic [ADDR_W-1:0] bw_addr_o,
   output logic [7:0]        bw_data_o,
   input  logic              bw_ack_i,
   input  logic              font_mode_i,
   input  logic              rd_we_i,
   input  logic [PTR_W-1:0]  rd_ptr_i,
   output logic [PTR_W-1:0]  fill_o,
   output logic              init_req_o,
   input  logic              init_ack_i
);

   if (BUF_BASE < 0 || (longint'(BUF_BASE) + prb_pkg::prb_max(CAP_NORM, CAP_FONT))
       > (longint'(1) << ADDR_W)) begin : g_bad_base
      $error("prb_port_rx: buffer does not fit the address space");
   end

   logic [8:0] sd_s;
   logic       init_s;
   logic       stb_q;
   logic       rise;
   logic       init_act;
   logic       pend_q;
   logic       clr;
   logic       full;
   logic       fsm_busy;
   logic       adv;
   logic [PTR_W-1:0] wptr;

   prb_sync #(
      .W       (9),
      .STAGES  (SYNC_STAGES),
      .RST_VAL (9'h100)
   ) i_sync_bus (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .d_i    ({hstrobe_ni, hdata_i}),
      .q_o    (sd_s)
   );

   prb_sync #(
      .W       (1),
      .STAGES  (SYNC_STAGES),
      .RST_VAL (1'b1)
   ) i_sync_init (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .d_i    (hinit_ni),
      .q_o    (init_s)
   );

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         stb_q  <= 1'b1;
         pend_q <= 1'b0;
      end else begin
         stb_q  <= sd_s[8];
         pend_q <= init_act | (pend_q & ~init_ack_i);
      end
   end

   assign rise     = sd_s[8] & ~stb_q;
   assign init_act = ~init_s;
   assign clr      = pend_q & init_ack_i;

   prb_hshake #(
      .ACK_CYCLES (ACK_CYCLES)
   ) i_hshake (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .rise_i     (rise),
      .data_i     (sd_s[7:0]),
      .init_act_i (init_act),
      .hold_i     (pend_q | full),
      .wr_ack_i   (bw_ack_i),
      .busy_o     (fsm_busy),
      .ack_n_o    (hack_no),
      .req_o      (bw_req_o),
      .byte_o     (bw_data_o),
      .adv_o      (adv)
   );

   prb_ring #(
      .PTR_W    (PTR_W),
      .CAP_NORM (CAP_NORM),
      .CAP_FONT (CAP_FONT)
   ) i_ring (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .font_mode_i (font_mode_i),
      .clr_i       (clr),
      .adv_i       (adv),
      .rd_we_i     (rd_we_i),
      .rd_ptr_i    (rd_ptr_i),
      .wptr_o      (wptr),
      .fill_o      (fill_o),
      .full_o      (full)
   );

   assign bw_addr_o  = ADDR_W'(BUF_BASE) + ADDR_W'(wptr);
   assign init_req_o = pend_q;
   assign hbusy_o    = ~hinit_ni | init_act | pend_q | fsm_busy | full;

   // R6
   init_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(init_req_o) |-> $past(init_ack_i));

   // R1
   req_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      bw_req_o |-> hbusy_o);

endmodule

// File: tb/test_prb_port_rx.sv
module test_prb_port_rx;

   localparam int CAP_NORM   = 37888;
   localparam int CAP_FONT   = 3072;
   localparam int ACK_CYCLES = 8;
   localparam int PTR_W      = 16;

   logic clk = 1'b0;
   always #2 clk = ~clk;

   logic        rst_n = 1'b0;
   logic [7:0]  hdata = '0;
   logic        hstrobe_n = 1'b1;
   logic        hinit_n = 1'b1;
   logic        hbusy, hack_n, bw_req, bw_ack = 1'b0;
   logic [15:0] bw_addr;
   logic [7:0]  bw_data;
   logic        font_mode = 1'b0;
   logic        rd_we = 1'b0;
   logic [PTR_W-1:0] rd_ptr = '0;
   logic [PTR_W-1:0] fill;
   logic        init_req;
   logic        init_ack = 1'b0;

   prb_port_rx i_prb_port_rx (
      .clk_i (clk), .rst_ni (rst_n),
      .hdata_i (hdata), .hstrobe_ni (hstrobe_n), .hinit_ni (hinit_n),
      .hbusy_o (hbusy), .hack_no (hack_n),
      .bw_req_o (bw_req), .bw_addr_o (bw_addr), .bw_data_o (bw_data), .bw_ack_i (bw_ack),
      .font_mode_i (font_mode), .rd_we_i (rd_we), .rd_ptr_i (rd_ptr),
      .fill_o (fill), .init_req_o (init_req), .init_ack_i (init_ack)
   );

   int n_chk = 0;
   int n_err = 0;

   task automatic chk(input string tag, input longint act, input longint exp);
      n_chk++;
      if (act != exp) begin
         n_err++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // behavioural reference model
   bit [8:0]  q_sd[$];
   bit        q_in[$];
   bit        m_sq, m_mode, m_pend;
   int        m_state, m_cnt, m_w, m_r;
   bit [7:0]  m_byte;

   function automatic int m_cap();
      return m_mode ? CAP_FONT : CAP_NORM;
   endfunction
   function automatic int m_fill();
      return (m_w - m_r + m_cap()) % m_cap();
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q_sd = {9'h100, 9'h100};
         q_in = {1'b1, 1'b1};
         m_sq = 1; m_mode = 0; m_pend = 0;
         m_state = 0; m_cnt = 0; m_w = 0; m_r = 0; m_byte = 0;
      end else begin
         bit [8:0] sd;
         bit ini, rise, act, full, clr, adv;
         int cap;
         sd   = q_sd[0];
         ini  = q_in[0];
         cap  = m_cap();
         full = (m_fill() == cap - 1);
         rise = sd[8] && !m_sq;
         act  = !ini;
         clr  = (m_pend && init_ack) || (font_mode != m_mode);
         adv  = (m_state == 1) && bw_ack && !act;
         if (act) m_state = 0;
         else begin
            case (m_state)
               0: if (rise && !m_pend && !full) begin m_byte = sd[7:0]; m_state = 1; end
               1: if (bw_ack) begin m_state = 2; m_cnt = ACK_CYCLES - 1; end
               default: if (m_cnt == 0) m_state = 0; else m_cnt--;
            endcase
         end
         if (clr) begin m_w = 0; m_r = 0; end
         else begin
            if (adv) m_w = (m_w + 1) % cap;
            if (rd_we && rd_ptr < cap) m_r = rd_ptr;
         end
         m_pend = act || (m_pend && !init_ack);
         m_mode = font_mode;
         m_sq   = sd[8];
         void'(q_sd.pop_front()); q_sd.push_back({hstrobe_n, hdata});
         void'(q_in.pop_front()); q_in.push_back(hinit_n);
      end
   end

   // every-cycle comparison against the model
   always @(negedge clk) begin
      if (rst_n) begin
         bit eb;
         eb = !hinit_n || m_pend || !q_in[0] || (m_state != 0) || (m_fill() == m_cap() - 1);
         chk("R2 busy", hbusy, eb);
         chk("R2 ack_n", hack_n, m_state != 2);
         chk("R1 req", bw_req, m_state == 1);
         if (m_state == 1) begin
            chk("R1 addr", bw_addr, m_w);
            chk("R1 data", bw_data, m_byte);
         end
         chk("R4 fill", fill, m_fill());
         chk("R6 init_req", init_req, m_pend);
      end
   end

   // ACK pulse length monitor
   int ack_run = 0;
   always @(negedge clk) begin
      if (rst_n) begin
         if (!hack_n) ack_run++;
         else begin
            if (ack_run != 0) chk("R2 ack length", ack_run, ACK_CYCLES);
            ack_run = 0;
         end
      end
   end

   // memory-side responder and byte scoreboard
   bit [7:0] sent[$];
   int lat = 0, wcnt = 0, req_seen = 0;
   always @(negedge clk) begin
      if (!rst_n) bw_ack <= 1'b0;
      else if (bw_req && !bw_ack) begin
         if (wcnt >= lat) begin
            bw_ack <= 1'b1;
            wcnt = 0;
            req_seen++;
            if (sent.size() == 0) chk("R1 unexpected write", 1, 0);
            else chk("R1 stored byte", bw_data, sent.pop_front());
         end else wcnt++;
      end else bw_ack <= 1'b0;
   end

   int cyc = 0;
   always @(posedge clk) begin
      cyc++;
      if (cyc == 150000) begin
         n_chk++; n_err++;
         $display("FAIL watchdog R1..R10 actual=%0d expected=done", cyc);
         $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
         $finish;
      end
   end

   int exp_w = 0;

   task automatic send(input bit [7:0] b);
      @(negedge clk);
      while (hbusy) @(negedge clk);
      #1 hdata = b; sent.push_back(b);
      @(negedge clk); #1 hstrobe_n = 1'b0;
      repeat (2) @(negedge clk); #1 hstrobe_n = 1'b1;
      repeat (4) @(negedge clk);
      while (m_state != 0) @(negedge clk);
      exp_w = (exp_w + 1) % m_cap();
   endtask

   task automatic raw_strobe(input bit [7:0] b);
      @(negedge clk); #1 hdata = b;
      @(negedge clk); #1 hstrobe_n = 1'b0;
      repeat (2) @(negedge clk); #1 hstrobe_n = 1'b1;
      repeat (8) @(negedge clk);
   endtask

   task automatic set_rd(input int v);
      @(negedge clk); #1 rd_we = 1'b1; rd_ptr = PTR_W'(v);
      @(negedge clk); #1 rd_we = 1'b0;
   endtask

   task automatic set_mode(input bit m);
      @(negedge clk); #1 font_mode = m;
      @(negedge clk);
   endtask

   initial begin
      int rs;
      repeat (3) @(negedge clk);
      #1 rst_n = 1'b1;
      @(negedge clk);
      // R10 reset state
      chk("R10 busy", hbusy, 0);
      chk("R10 ack_n", hack_n, 1);
      chk("R10 req", bw_req, 0);
      chk("R10 fill", fill, 0);
      chk("R10 init_req", init_req, 0);

      // R1 / R2 bytes with zero and longer write latency
      lat = 0;
      send(8'h41); send(8'h42); send(8'h43);
      lat = 3;
      send(8'hA5); send(8'h00);
      lat = 0;
      @(negedge clk);
      chk("R4 fill after five bytes", fill, 5);

      // R9 read-pointer updates
      set_rd(1);
      chk("R9 accepted pointer", fill, 4);
      set_rd(40000);
      chk("R9 out-of-range pointer ignored", fill, 4);

      // R8 mode switch clears and selects the small capacity
      set_mode(1'b1);
      chk("R8 fill cleared on mode change", fill, 0);
      exp_w = 0;
      for (int i = 0; i < 5; i++) send(8'(i + 16));
      set_rd(10);
      chk("R8 small capacity modulo", fill, CAP_FONT - 5);
      set_rd(5);
      chk("R8 drained", fill, 0);

      // R3 wrap of the write pointer
      for (int i = 0; i < CAP_FONT - 5; i++) begin
         send(8'(i * 7));
         if ((i % 1000) == 999) set_rd(exp_w);
      end
      set_rd(0);
      chk("R3 write pointer wrapped to zero", fill, 0);

      // R4 full buffer holds BUSY and ignores strobes
      set_rd(2);
      chk("R4 near full", fill, CAP_FONT - 2);
      send(8'h5A);
      repeat (3) @(negedge clk);
      chk("R4 busy when full", hbusy, 1);
      chk("R4 fill at limit", fill, CAP_FONT - 1);
      rs = req_seen;
      raw_strobe(8'hEE);
      chk("R4 strobe ignored when full", req_seen, rs);
      chk("R4 fill unchanged when full", fill, CAP_FONT - 1);
      set_rd(exp_w);
      chk("R4 busy released after drain", hbusy, 0);

      // R5 / R6 / R7 initialize
      send(8'h33);
      @(negedge clk);
      chk("R6 fill before init", fill, 1);
      @(negedge clk); #1 hinit_n = 1'b0;
      #1 chk("R5 busy immediate on init", hbusy, 1);
      repeat (4) @(negedge clk);
      chk("R6 init_req raised", init_req, 1);
      rs = req_seen;
      raw_strobe(8'h99);
      chk("R7 strobe ignored while init low", req_seen, rs);
      @(negedge clk); #1 hinit_n = 1'b1;
      repeat (4) @(negedge clk);
      chk("R6 init_req held until ack", init_req, 1);
      chk("R6 busy held until ack", hbusy, 1);
      raw_strobe(8'h98);
      chk("R7 strobe ignored while pending", req_seen, rs);
      @(negedge clk); #1 init_ack = 1'b1;
      @(negedge clk); #1 init_ack = 1'b0;
      chk("R6 pointers cleared by ack", fill, 0);
      chk("R6 init_req cleared", init_req, 0);
      exp_w = 0;
      send(8'h77);
      @(negedge clk);
      chk("R1 byte after init", fill, 1);

      // R8 back to normal capacity
      set_mode(1'b0);
      chk("R8 fill cleared on return", fill, 0);
      exp_w = 0;
      send(8'h12);
      @(negedge clk);
      chk("R8 normal mode write", fill, 1);

      repeat (5) @(negedge clk);
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

endmodule